// File: doc/BRIEF.md
# Serial Clock Rate Generator with Periodic Timer

This block divides the system clock with a reloadable down-counter. Software loads a 16-bit reload value as two byte writes, one for the upper byte and one for the lower byte. When the serial function is enabled and the port acts as bus master, the counter expiry toggles the serial clock, so the serial clock runs at the system clock divided by twice the reload value. Each toggle also raises a one-cycle edge strobe for the shift logic.

When the serial function is switched off (mode field 2'b00) and the timer enable is set, the same counter runs as a free-running periodic timer. It raises a one-cycle timeout pulse each time it expires and then reloads by itself. A reload value of zero counts as 65536. Reload writes never cut a count short: a new value is picked up at the next reload. The correct setup order for the timer is to clear the mode field, write both bytes, and then set the timer enable.

Top module: `sck_rate_timer`

## Requirements
- R1: The reload value is {upper byte, lower byte}. A write with `wr_hi_i` stores `wr_data_i` into bits 15:8, and a write with `wr_lo_i` stores it into bits 7:0.
- R2: With `mode_i == 2'b00` and `tmr_en_i == 1`, `tmo_o` first pulses R cycles after the enable is sampled and then every R cycles. `master_i` has no effect in this mode.
- R3: A reload value of 16'h0000 counts as 65536 cycles.
- R4: For a reload value of 2 or more, `tmo_o` is high for exactly one cycle per expiry.
- R5: With `mode_i != 2'b00` and `master_i == 1`, `sck_o` toggles every R cycles and starts at 0. Each toggle comes with a one-cycle pulse on `sck_edge_o`.
- R6: A reload write during an active count does not alter that count. The new value governs the following periods.
- R7: With `mode_i == 2'b00` and `tmr_en_i == 0`, the counter is held at the reload value, `sck_o` stays 0 and no pulse appears.
- R8: With `mode_i != 2'b00` and `master_i == 0`, the counter is held, `sck_o` stays 0 and neither `sck_edge_o` nor `tmo_o` pulses, even when `tmr_en_i` is set.
- R9: In master operation `tmr_en_i` is ignored and `tmo_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_hi_i | input | 1 | Write strobe for the upper reload byte |
| wr_lo_i | input | 1 | Write strobe for the lower reload byte |
| wr_data_i | input | BYTE_W | Byte to store |
| mode_i | input | 2 | Serial enable field, 2'b00 means off |
| tmr_en_i | input | 1 | Timer function enable |
| master_i | input | 1 | Port is bus master |
| sck_o | output | 1 | Generated serial clock |
| sck_edge_o | output | 1 | One-cycle strobe on every serial clock toggle |
| tmo_o | output | 1 | One-cycle timer timeout pulse |

## Verification
The bench builds the block with its default BYTE_W of 8, which gives a full 16-bit counter. This reaches the real corner of a zero reload counting 65536 cycles, along with short reloads of 1 and 2 where the pulses sit back to back. A reload of 259 shows that both bytes take part in the count. A reload changed in the middle of a timer period shows that the running count completes with its old value.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;
    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_TIMER  = 2'd1,
        RUN_MASTER = 2'd2
    } run_e;

    function automatic run_e decode_run(input logic [1:0] mode, input logic tmr_en,
                                        input logic master);
        if (mode == 2'b00) return tmr_en ? RUN_TIMER : RUN_IDLE;
        return master ? RUN_MASTER : RUN_IDLE;
    endfunction
endpackage

// File: rtl/sck_reload_regs.sv
module sck_reload_regs #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [CNT_W-1:0]  reload_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_hi_i) regs_d.hi = wr_data_i;
        if (wr_lo_i) regs_d.lo = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign reload_o = {regs_q.hi, regs_q.lo};

    // R1: an upper-byte write lands in the upper half only
    p_hi_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_lo_i) |=> (reload_o[CNT_W-1:BYTE_W] == $past(wr_data_i))
                                  && (reload_o[BYTE_W-1:0] == $past(reload_o[BYTE_W-1:0])));
endmodule

// File: rtl/sck_down_counter.sv
module sck_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!run_i) begin
            st_d.cnt = reload_i;
        end else if (st_q.cnt == ONE) begin
            expire_o = 1'b1;
            st_d.cnt = reload_i;
        end else begin
            // zero wraps to all ones, giving a full 2**CNT_W count
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: while stopped the count tracks the reload value
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> (st_q.cnt == $past(reload_i)));
    // R6: an expiry loads the reload value present at that edge
    p_expire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (st_q.cnt == $past(reload_i)));
endmodule

// File: rtl/sck_rate_timer.sv
module sck_rate_timer #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [1:0]        mode_i,
    input  logic              tmr_en_i,
    input  logic              master_i,
    output logic              sck_o,
    output logic              sck_edge_o,
    output logic              tmo_o
);
    import sck_rate_pkg::*;

    typedef struct packed {
        logic sck;
        logic edge_s;
        logic tmo;
    } out_t;

    logic [CNT_W-1:0] reload;
    logic             expire;
    run_e             run;
    out_t             out_d, out_q;

    assign run = decode_run(mode_i, tmr_en_i, master_i);

    sck_reload_regs #(.BYTE_W(BYTE_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi_i   (wr_hi_i),
        .wr_lo_i   (wr_lo_i),
        .wr_data_i (wr_data_i),
        .reload_o  (reload)
    );

    sck_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run != RUN_IDLE),
        .reload_i (reload),
        .expire_o (expire)
    );

    always_comb begin
        out_d        = out_q;
        out_d.edge_s = 1'b0;
        out_d.tmo    = 1'b0;
        unique case (run)
            RUN_MASTER: begin
                if (expire) begin
                    out_d.sck    = ~out_q.sck;
                    out_d.edge_s = 1'b1;
                end
            end
            RUN_TIMER: begin
                out_d.sck = 1'b0;
                out_d.tmo = expire;
            end
            default: out_d.sck = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sck_o      = out_q.sck;
    assign sck_edge_o = out_q.edge_s;
    assign tmo_o      = out_q.tmo;

    // R2, R9: timeout only follows a cycle in timer operation
    p_tmo_timer_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> ($past(run) == RUN_TIMER));
    // R5: every edge strobe matches a clock toggle
    p_edge_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sck_edge_o |-> (sck_o != $past(sck_o)));
    // R8: outside master operation the serial clock rests low
    p_sck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) != RUN_MASTER) |-> (!sck_o && !sck_edge_o));
endmodule

// File: tb/test_sck_rate_timer.sv
module test_sck_rate_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_hi = 1'b0, wr_lo = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode = 2'b00;
    logic       tmr_en = 1'b0, master = 1'b0;
    logic       sck, sck_edge, tmo;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sck_rate_timer i_sck_rate_timer (
        .clk(clk), .rst_n(rst_n), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_data_i(wr_data),
        .mode_i(mode), .tmr_en_i(tmr_en), .master_i(master),
        .sck_o(sck), .sck_edge_o(sck_edge), .tmo_o(tmo)
    );

    // kind: 0 timer pulses, 1 master clock, 2 silent
    typedef struct packed {
        logic [15:0] r;
        logic [1:0]  mode;
        logic        mst;
        logic        ten;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd5,   2'b00, 1'b0, 1'b1, 2'd0},
        '{16'd1,   2'b00, 1'b0, 1'b1, 2'd0},
        '{16'd2,   2'b00, 1'b1, 1'b1, 2'd0},
        '{16'd259, 2'b00, 1'b0, 1'b1, 2'd0},
        '{16'd3,   2'b01, 1'b1, 1'b0, 2'd1},
        '{16'd7,   2'b10, 1'b1, 1'b1, 2'd1},
        '{16'd4,   2'b11, 1'b0, 1'b1, 2'd2},
        '{16'd6,   2'b00, 1'b0, 1'b0, 2'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_reload(input logic [15:0] r);
        @(negedge clk); wr_hi = 1'b1; wr_data = r[15:8];
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = r[7:0];
        @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic go_idle();
        @(negedge clk); mode = 2'b00; tmr_en = 1'b0; master = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // count negedges until sig is high; sig 0 = tmo, 1 = sck_edge
    task automatic wait_pulse(input int which, output int n);
        n = 0;
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk); n++;
            if ((which == 0) ? tmo : sck_edge) return;
        end
    endtask

    initial begin
        int n;
        int r_eff;
        repeat (3) @(negedge clk);
        check("R7 reset sck", int'(sck), 0);
        check("R7 reset tmo", int'(tmo), 0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            go_idle();
            set_reload(VECS[i].r);
            repeat (2) @(negedge clk);
            mode = VECS[i].mode; master = VECS[i].mst; tmr_en = VECS[i].ten;
            r_eff = int'(VECS[i].r);
            case (VECS[i].kind)
                2'd0: begin
                    wait_pulse(0, n);
                    check("R2 R1 first timeout", n, r_eff);
                    check("R2 sck idle in timer", int'(sck), 0);
                    wait_pulse(0, n);
                    check("R2 timeout period", n, r_eff);
                    if (r_eff >= 2) begin
                        @(negedge clk);
                        check("R4 timeout width", int'(tmo), 0);
                    end
                end
                2'd1: begin
                    wait_pulse(1, n);
                    check("R5 first toggle", n, r_eff);
                    check("R5 sck rises", int'(sck), 1);
                    wait_pulse(1, n);
                    check("R5 half period", n, r_eff);
                    check("R5 sck falls", int'(sck), 0);
                    check("R9 no timeout in master", int'(tmo), 0);
                end
                default: begin
                    int seen = 0;
                    for (int k = 0; k < 200; k++) begin
                        @(negedge clk);
                        if (sck || sck_edge || tmo) seen++;
                    end
                    check("R7 R8 silent outputs", seen, 0);
                end
            endcase
        end

        // R6: reload change during a count takes effect afterwards
        go_idle();
        set_reload(16'd10);
        repeat (2) @(negedge clk);
        tmr_en = 1'b1;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk); n++;
            wr_lo = (n == 3); wr_data = 8'd4;
            if (tmo) break;
        end
        wr_lo = 1'b0;
        check("R6 running count kept", n, 10);
        wait_pulse(0, n);
        check("R6 new period", n, 4);

        // R3: zero reload counts 65536
        go_idle();
        set_reload(16'd0);
        repeat (2) @(negedge clk);
        tmr_en = 1'b1;
        wait_pulse(0, n);
        check("R3 zero reload", n, 65536);

        go_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule